// File: doc/BRIEF.md
# Master Transfer Byte Sequencer

This block is the byte-level sequencing layer of a serial bus master. It sits between a shared data FIFO (16 bytes by default) and a byte-oriented bus engine. The bit-level serial engine is outside this block. The sequencer sees it as a command handshake: a one-cycle command strobe, then a later one-cycle done pulse that carries the received byte. Software-side controls are plain ports:

- a control write that sets direction, hold and a self-clearing FIFO flush;
- a target-address write that starts a transaction;
- a transfer-size load;
- a byte push for transmit and a byte pop for receive.

In transmit mode the sequencer sends queued bytes until the FIFO is empty, and the size readback reports FIFO occupancy. In receive mode a down-counter tracks the bytes still expected. Every byte is acknowledged except the one that takes the counter to zero, which is refused whatever the hold setting. When the FIFO is full and hold is set, the bus is stalled. At the end of a transfer the block issues a stop when hold is clear. When hold is set it parks with the bus still owned, so a later address write produces a repeated start.

The sequencer is a Moore state machine with these states:

- IDLE
- ADDR_GO and ADDR_WAIT: address phase
- DECIDE: chooses the next step
- BYTE_GO and BYTE_WAIT: one data byte
- STALL: receive FIFO full with hold set
- END: completion cycle
- STOP_GO and STOP_WAIT: stop condition

Its transitions are:

- IDLE→ADDR_GO on an accepted start.
- IDLE→STOP_GO when the bus is parked and hold has been cleared.
- ADDR_GO→ADDR_WAIT, then ADDR_WAIT→DECIDE on done.
- DECIDE→END when the counter is zero (receive) or the FIFO is empty (transmit).
- DECIDE→STALL when receiving into a full FIFO with hold set.
- DECIDE→BYTE_GO otherwise.
- STALL→BYTE_GO once space frees or hold drops.
- BYTE_GO→BYTE_WAIT, then BYTE_WAIT→DECIDE on done.
- END→IDLE (parked) with hold set, and END→STOP_GO without it.
- STOP_GO→STOP_WAIT, then STOP_WAIT→IDLE on done.

Top module: `mst_byte_seq`

## Requirements
- R1: After reset the block is idle: no command strobe, bus_active low, size_q zero, no events, rx_valid low.
- R2: An address write accepted in IDLE raises a command strobe with code 1 (address) in the cycle after the write edge. With start_ext low eng_addr carries start_addr[6:0] with upper bits zero; with start_ext high it carries all 10 bits. eng_rnw equals the direction bit.
- R3: In transmit (direction 0) each queued byte is sent as one command with code 2 (data), in FIFO order, and each strobe lasts one cycle.
- R4: With direction 0, size_q returns the number of bytes held in the FIFO.
- R5: With direction 1, size_q returns the remaining receive count, which drops by one per received byte and never wraps below zero. Received bytes are popped in arrival order on pop_data.
- R6: In receive, eng_ack is 1 on each data command except the one issued while the count equals 1, which carries 0, independent of hold.
- R7: In receive with a full FIFO and hold set, no data command is issued until a byte is popped or hold drops. With hold clear the transfer continues and bytes arriving at a full FIFO are discarded.
- R8: ev_data pulses for one cycle in the cycle the receive FIFO count first reaches depth minus 2 (14).
- R9: ev_comp pulses for one cycle after the last byte is done: the count is zero (receive) or the FIFO is empty (transmit). A zero-length receive completes with no data command.
- R10: At the end of a transfer with hold clear, a command with code 3 (stop) is issued and bus_active falls after its done. With hold set, no stop is issued and bus_active stays high. Clearing hold while parked issues the stop.
- R11: A control write with the clear bit set empties the FIFO at the following edge, and the clear request lasts one cycle only.
- R12: An address write outside IDLE is ignored, and a direction change outside IDLE is ignored.
- R13: rx_valid is high exactly when the direction is receive and the FIFO is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_dir | input | 1 | Direction: 0 transmit, 1 receive |
| ctl_hold | input | 1 | Hold the bus at transfer end |
| ctl_clr | input | 1 | Request a FIFO flush |
| start_we | input | 1 | Address write; starts a transfer |
| start_addr | input | 10 | Target address |
| start_ext | input | 1 | 1 selects 10-bit addressing |
| size_we | input | 1 | Transfer size load strobe |
| size_wdata | input | 8 | Transfer size value |
| push_we | input | 1 | Push a transmit byte |
| push_data | input | 8 | Transmit byte |
| pop_re | input | 1 | Pop a received byte |
| pop_data | output | 8 | FIFO head byte |
| size_q | output | 8 | Remaining count (receive) or FIFO occupancy (transmit) |
| rx_valid | output | 1 | Received data available |
| bus_active | output | 1 | Bus owned by this master |
| ev_data | output | 1 | Receive threshold event pulse |
| ev_comp | output | 1 | Transfer completion pulse |
| eng_valid | output | 1 | Command strobe to the bus engine |
| eng_cmd | output | 2 | Command code: 0 none, 1 address, 2 data, 3 stop |
| eng_addr | output | 10 | Address for the address command |
| eng_rnw | output | 1 | Transfer direction to the engine |
| eng_wdata | output | 8 | Byte for a transmit data command |
| eng_ack | output | 1 | Acknowledge (1) or refuse (0) the received byte |
| eng_done | input | 1 | Engine finished the current command |
| eng_rdata | input | 8 | Byte received, valid with eng_done |

## Verification
Control timing:
- An accepted address write shows its address strobe in the very next cycle.
- An engine done pulse sampled at one edge leads, through a single decision cycle, to the next command strobe two edges later.
- Completion is visible the cycle after the decision that found the count at zero or the FIFO empty.

Data timing:
- The threshold event shares the cycle in which the count first reads 14.
- A clear request empties the FIFO two edges after the write edge.

The bench steps a behavioural model built on queues and integers at each rising edge. It compares every output against that model at the following falling edge, so each result is sampled in the exact cycle it is due.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ADDR = 2'd1,
        CMD_DATA = 2'd2,
        CMD_STOP = 2'd3
    } bus_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_GO,
        ST_ADDR_WAIT,
        ST_DECIDE,
        ST_BYTE_GO,
        ST_BYTE_WAIT,
        ST_STALL,
        ST_END,
        ST_STOP_GO,
        ST_STOP_WAIT
    } seq_state_e;
endpackage

// File: rtl/mbs_fifo.sv
module mbs_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             push_acc_o,
    output logic             pop_acc_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o     = (cnt_q == CW'(DEPTH));
    assign empty_o    = (cnt_q == '0);
    assign push_acc_o = push_i && !full_o && !flush_i;
    assign pop_acc_o  = pop_i && !empty_o && !flush_i;
    assign head_o     = mem_q[rd_ptr_q];
    assign count_o    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_acc_o) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_acc_o)  rd_ptr_q <= bump(rd_ptr_q);
            cnt_q <= cnt_q + CW'(push_acc_o) - CW'(pop_acc_o);
        end
    end

    always_ff @(posedge clk) begin
        if (push_acc_o) mem_q[wr_ptr_q] <= push_data_i;
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/mbs_size_ctr.sv
module mbs_size_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_i)               cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
    assign last_o = (cnt_q == W'(1));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rx_i,
    input  logic       hold_i,
    input  logic       cnt_zero_i,
    input  logic       fifo_full_i,
    input  logic       fifo_empty_i,
    input  logic       eng_done_i,
    output seq_state_e state_o,
    output logic       eng_valid_o,
    output bus_cmd_e   eng_cmd_o,
    output logic       byte_go_o,
    output logic       byte_done_o,
    output logic       comp_o,
    output logic       bus_active_o,
    output logic       idle_o
);
    seq_state_e st_q, st_d;
    logic       held_q, held_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            held_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            held_q <= held_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        held_d = held_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i)              st_d = ST_ADDR_GO;
                else if (held_q && !hold_i) st_d = ST_STOP_GO;
            end
            ST_ADDR_GO:   st_d = ST_ADDR_WAIT;
            ST_ADDR_WAIT: if (eng_done_i) st_d = ST_DECIDE;
            ST_DECIDE: begin
                if (rx_i) begin
                    if (cnt_zero_i)                   st_d = ST_END;
                    else if (fifo_full_i && hold_i)   st_d = ST_STALL;
                    else                              st_d = ST_BYTE_GO;
                end else begin
                    if (fifo_empty_i) st_d = ST_END;
                    else              st_d = ST_BYTE_GO;
                end
            end
            ST_STALL:     if (!(fifo_full_i && hold_i)) st_d = ST_BYTE_GO;
            ST_BYTE_GO:   st_d = ST_BYTE_WAIT;
            ST_BYTE_WAIT: if (eng_done_i) st_d = ST_DECIDE;
            ST_END: begin
                if (hold_i) begin
                    st_d   = ST_IDLE;
                    held_d = 1'b1;
                end else begin
                    st_d = ST_STOP_GO;
                end
            end
            ST_STOP_GO:   st_d = ST_STOP_WAIT;
            ST_STOP_WAIT: begin
                if (eng_done_i) begin
                    st_d   = ST_IDLE;
                    held_d = 1'b0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_valid_o = 1'b0;
        eng_cmd_o   = CMD_NONE;
        unique case (st_q)
            ST_ADDR_GO: begin eng_valid_o = 1'b1; eng_cmd_o = CMD_ADDR; end
            ST_BYTE_GO: begin eng_valid_o = 1'b1; eng_cmd_o = CMD_DATA; end
            ST_STOP_GO: begin eng_valid_o = 1'b1; eng_cmd_o = CMD_STOP; end
            default:    ;
        endcase
    end

    assign state_o      = st_q;
    assign byte_go_o    = (st_q == ST_BYTE_GO);
    assign byte_done_o  = (st_q == ST_BYTE_WAIT) && eng_done_i;
    assign comp_o       = (st_q == ST_END);
    assign idle_o       = (st_q == ST_IDLE);
    assign bus_active_o = (st_q != ST_IDLE) || held_q;

    assert_cmd_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid_o |=> !eng_valid_o);

    assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_active_o) |-> $past(st_q == ST_STOP_WAIT && eng_done_i));

    assert_stall_only_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL) |-> rx_i);
endmodule

// File: rtl/mst_byte_seq.sv
module mst_byte_seq
    import mbs_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int SIZE_W   = 8,
    parameter int ADDR_W   = 10,
    parameter int NARROW_W = 7,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int THRESH  = DEPTH - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_dir,
    input  logic              ctl_hold,
    input  logic              ctl_clr,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_ext,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_wdata,
    input  logic              push_we,
    input  logic [7:0]        push_data,
    input  logic              pop_re,
    output logic [7:0]        pop_data,
    output logic [SIZE_W-1:0] size_q,
    output logic              rx_valid,
    output logic              bus_active,
    output logic              ev_data,
    output logic              ev_comp,
    output logic              eng_valid,
    output logic [1:0]        eng_cmd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_rnw,
    output logic [7:0]        eng_wdata,
    output logic              eng_ack,
    input  logic              eng_done,
    input  logic [7:0]        eng_rdata
);
    logic              dir_q, hold_q, clr_q, ev_data_q;
    logic [ADDR_W-1:0] addr_q;
    logic              idle, start_acc;
    logic              byte_go, byte_done, comp, busy_out;
    seq_state_e        state;
    bus_cmd_e          cmd;
    logic              f_push, f_pop, f_full, f_empty, f_pacc, f_popacc;
    logic [7:0]        f_din, f_head;
    logic [CW-1:0]     f_count;
    logic [SIZE_W-1:0] cnt;
    logic              cnt_zero, cnt_last;

    assign start_acc = start_we && idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            hold_q    <= 1'b0;
            clr_q     <= 1'b0;
            addr_q    <= '0;
            ev_data_q <= 1'b0;
        end else begin
            if (ctl_we) begin
                hold_q <= ctl_hold;
                if (idle) dir_q <= ctl_dir;
            end
            clr_q <= ctl_we && ctl_clr;
            if (start_acc)
                addr_q <= start_ext ? start_addr
                                    : ADDR_W'(start_addr[NARROW_W-1:0]);
            ev_data_q <= dir_q && f_pacc && !f_popacc && (f_count == CW'(THRESH - 1));
        end
    end

    assign f_push = dir_q ? byte_done : push_we;
    assign f_din  = dir_q ? eng_rdata : push_data;
    assign f_pop  = dir_q ? pop_re    : byte_go;

    mbs_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (clr_q),
        .push_i     (f_push),
        .push_data_i(f_din),
        .pop_i      (f_pop),
        .head_o     (f_head),
        .count_o    (f_count),
        .full_o     (f_full),
        .empty_o    (f_empty),
        .push_acc_o (f_pacc),
        .pop_acc_o  (f_popacc)
    );

    mbs_size_ctr #(.W(SIZE_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (size_we),
        .load_val_i(size_wdata),
        .dec_i     (dir_q && byte_done),
        .cnt_o     (cnt),
        .zero_o    (cnt_zero),
        .last_o    (cnt_last)
    );

    mbs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_acc),
        .rx_i        (dir_q),
        .hold_i      (hold_q),
        .cnt_zero_i  (cnt_zero),
        .fifo_full_i (f_full),
        .fifo_empty_i(f_empty),
        .eng_done_i  (eng_done),
        .state_o     (state),
        .eng_valid_o (eng_valid),
        .eng_cmd_o   (cmd),
        .byte_go_o   (byte_go),
        .byte_done_o (byte_done),
        .comp_o      (comp),
        .bus_active_o(busy_out),
        .idle_o      (idle)
    );

    assign eng_cmd    = cmd;
    assign eng_addr   = addr_q;
    assign eng_rnw    = dir_q;
    assign eng_wdata  = f_head;
    assign eng_ack    = dir_q ? !cnt_last : 1'b1;
    assign pop_data   = f_head;
    assign size_q     = dir_q ? cnt : SIZE_W'(f_count);
    assign rx_valid   = dir_q && !f_empty;
    assign bus_active = busy_out;
    assign ev_data    = ev_data_q;
    assign ev_comp    = comp;

    assert_thresh_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_data_q |-> (f_count == CW'(THRESH)) && dir_q);

    assert_dir_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(dir_q));
endmodule

// File: tb/mst_byte_seq_test.sv
module mst_byte_seq_test;
    localparam int DEPTH = 16;
    localparam int THR   = DEPTH - 2;
    localparam int LAT   = 3;
    localparam int P_IDLE = 0, P_AGO = 1, P_AWAIT = 2, P_DEC = 3, P_BGO = 4,
                   P_BWAIT = 5, P_STALL = 6, P_END = 7, P_SGO = 8, P_SWAIT = 9;

    logic clk = 0, rst_n = 0;
    logic ctl_we = 0, ctl_dir = 0, ctl_hold = 0, ctl_clr = 0;
    logic start_we = 0, start_ext = 0;
    logic [9:0] start_addr = 0;
    logic size_we = 0; logic [7:0] size_wdata = 0;
    logic push_we = 0; logic [7:0] push_data = 0;
    logic pop_re = 0;
    logic [7:0] pop_data, size_q, eng_wdata;
    logic rx_valid, bus_active, ev_data, ev_comp, eng_valid, eng_rnw, eng_ack;
    logic [1:0] eng_cmd;
    logic [9:0] eng_addr;
    logic eng_done = 0; logic [7:0] eng_rdata = 0;

    mst_byte_seq uut (.*);

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0, run_cmp = 0;

    task automatic check(string tag, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    int m_ph, m_cnt, m_sz, m_nph;
    logic [7:0] m_q[$];
    bit m_dir, m_hold, m_clr, m_held, m_ev;
    int m_addr;
    bit mf_full, mf_empty, mf_bdone, mf_push, mf_pop, mf_pa, mf_po;
    logic [7:0] mf_pd;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = P_IDLE; m_cnt = 0; m_q.delete(); m_dir = 0; m_hold = 0;
            m_clr = 0; m_held = 0; m_ev = 0; m_addr = 0;
        end else begin
            m_sz     = m_q.size();
            mf_full  = (m_sz == DEPTH);
            mf_empty = (m_sz == 0);
            mf_bdone = (m_ph == P_BWAIT) && eng_done;
            mf_push  = m_dir ? mf_bdone : push_we;
            mf_pd    = m_dir ? eng_rdata : push_data;
            mf_pop   = m_dir ? pop_re : (m_ph == P_BGO);
            m_nph = m_ph;
            case (m_ph)
                P_IDLE:  if (start_we) m_nph = P_AGO;
                         else if (m_held && !m_hold) m_nph = P_SGO;
                P_AGO:   m_nph = P_AWAIT;
                P_AWAIT: if (eng_done) m_nph = P_DEC;
                P_DEC:   if (m_dir) m_nph = (m_cnt == 0) ? P_END : ((mf_full && m_hold) ? P_STALL : P_BGO);
                         else m_nph = mf_empty ? P_END : P_BGO;
                P_STALL: if (!(mf_full && m_hold)) m_nph = P_BGO;
                P_BGO:   m_nph = P_BWAIT;
                P_BWAIT: if (eng_done) m_nph = P_DEC;
                P_END:   if (m_hold) begin m_nph = P_IDLE; m_held = 1; end else m_nph = P_SGO;
                P_SGO:   m_nph = P_SWAIT;
                P_SWAIT: if (eng_done) begin m_nph = P_IDLE; m_held = 0; end
                default: m_nph = P_IDLE;
            endcase
            mf_pa = !m_clr && mf_push && !mf_full;
            mf_po = !m_clr && mf_pop && !mf_empty;
            m_ev  = m_dir && mf_pa && !mf_po && (m_sz == THR - 1);
            if (m_clr) m_q.delete();
            else begin
                if (mf_po) void'(m_q.pop_front());
                if (mf_pa) m_q.push_back(mf_pd);
            end
            if (size_we) m_cnt = size_wdata;
            else if (m_dir && mf_bdone && m_cnt != 0) m_cnt--;
            if (start_we && m_ph == P_IDLE) m_addr = start_ext ? start_addr : (start_addr & 10'h7F);
            if (ctl_we) begin m_hold = ctl_hold; if (m_ph == P_IDLE) m_dir = ctl_dir; end
            m_clr = ctl_we && ctl_clr;
            m_ph = m_nph;
        end
    end

    // per-cycle comparison
    always @(negedge clk) if (rst_n && run_cmp && !finished) begin
        int ecmd;
        ecmd = (m_ph == P_AGO) ? 1 : (m_ph == P_BGO) ? 2 : (m_ph == P_SGO) ? 3 : 0;
        check(ecmd == 1 ? "R2" : ecmd == 3 ? "R10" : ecmd == 2 ? "R3" : "R7", eng_cmd, ecmd);
        check(ecmd == 1 ? "R2" : "R3", eng_valid, ecmd != 0);
        if (m_ph == P_AGO) begin check("R2", eng_addr, m_addr); check("R2", eng_rnw, m_dir); end
        if (m_ph == P_BGO && !m_dir && m_q.size() > 0) check("R3", eng_wdata, m_q[0]);
        if (m_ph == P_BGO && m_dir) check("R6", eng_ack, m_cnt != 1);
        check(m_dir ? "R5" : "R4", size_q, m_dir ? m_cnt : m_q.size());
        check("R8", ev_data, m_ev);
        check("R9", ev_comp, m_ph == P_END);
        check("R10", bus_active, (m_ph != P_IDLE) || m_held);
        check("R13", rx_valid, m_dir && m_q.size() != 0);
        if (m_dir && m_q.size() != 0) check("R5", pop_data, m_q[0]);
    end

    // ---------------- bus engine responder ----------------
    int tmr = 0, addr_cnt = 0, data_cnt = 0, stop_cnt = 0;
    logic [7:0] rd_ctr = 8'h10;
    logic [7:0] tx_log[$], rx_log[$];
    bit pend_data = 0;
    always @(negedge clk) begin
        eng_done = 0;
        if (tmr > 0) begin
            tmr--;
            if (tmr == 0) begin
                eng_done = 1; eng_rdata = rd_ctr;
                if (pend_data) rx_log.push_back(rd_ctr);
                rd_ctr++;
            end
        end
        if (rst_n && eng_valid) begin
            tmr = LAT;
            pend_data = (eng_cmd == 2'd2) && eng_rnw;
            if (eng_cmd == 2'd1) addr_cnt++;
            if (eng_cmd == 2'd2) begin data_cnt++; if (!eng_rnw) tx_log.push_back(eng_wdata); end
            if (eng_cmd == 2'd3) stop_cnt++;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) if (cyc > 150000 && !finished) begin
        finished = 1; fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr_ctl(bit d, bit h, bit c);
        @(negedge clk); ctl_we = 1; ctl_dir = d; ctl_hold = h; ctl_clr = c;
        @(negedge clk); ctl_we = 0; ctl_clr = 0;
    endtask
    task automatic do_push(logic [7:0] b);
        @(negedge clk); push_we = 1; push_data = b;
        @(negedge clk); push_we = 0;
    endtask
    task automatic do_start(logic [9:0] a, bit e);
        @(negedge clk); start_we = 1; start_addr = a; start_ext = e;
        @(negedge clk); start_we = 0;
    endtask
    task automatic do_size(int n);
        @(negedge clk); size_we = 1; size_wdata = n[7:0];
        @(negedge clk); size_we = 0;
    endtask
    task automatic do_pop();
        @(negedge clk); pop_re = 1;
        @(negedge clk); pop_re = 0;
    endtask
    task automatic wait_comp();
        do @(negedge clk); while (!ev_comp);
    endtask
    task automatic wait_free();
        do @(negedge clk); while (bus_active);
    endtask

    initial begin
        logic [7:0] exp_b;
        int got_addr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", eng_valid, 0); check("R1", bus_active, 0); check("R1", size_q, 0);
        check("R1", ev_comp, 0);   check("R1", ev_data, 0);    check("R1", rx_valid, 0);
        rst_n = 1; run_cmp = 1;
        @(negedge clk);

        // transmit, 7-bit address, stop at end; mid-transfer start and dir writes ignored (R12)
        do_size(7);
        wr_ctl(0, 0, 0);
        for (int i = 0; i < 5; i++) do_push(8'hA0 + 8'(i));
        check("R4", size_q, 5);
        do_start(10'h2D5, 0);
        check("R2", eng_addr, 10'h055);
        repeat (4) @(negedge clk);
        do_start(10'h111, 0);
        wr_ctl(1, 0, 0);
        wait_free();
        check("R3", tx_log.size(), 5);
        for (int i = 0; i < 5 && i < tx_log.size(); i++) check("R3", tx_log[i], 8'hA0 + i);
        check("R12", addr_cnt, 1);
        check("R12", size_q, 0);
        check("R10", stop_cnt, 1);

        // transmit, 10-bit address, hold set: parks without stop
        wr_ctl(0, 1, 0);
        for (int i = 0; i < 3; i++) do_push(8'hC0 + 8'(i));
        do_start(10'h2D5, 1);
        check("R2", eng_addr, 10'h2D5);
        wait_comp();
        repeat (3) @(negedge clk);
        check("R10", bus_active, 1);
        check("R10", stop_cnt, 1);

        // repeated start into a receive of 20 with hold: stall at full FIFO
        wr_ctl(1, 1, 0);
        do_size(20);
        rx_log.delete();
        do_start(10'h033, 0);
        repeat (150) @(negedge clk);
        check("R7", size_q, 4);
        check("R7", data_cnt, 5 + 3 + 16);
        for (int n = 0; n < 20; n++) begin
            while (!rx_valid) @(negedge clk);
            exp_b = (n < rx_log.size()) ? rx_log[n] : 8'h00;
            check("R5", pop_data, exp_b);
            do_pop();
        end
        repeat (10) @(negedge clk);
        check("R5", size_q, 0);
        check("R10", bus_active, 1);
        wr_ctl(1, 0, 0);
        wait_free();
        check("R10", stop_cnt, 2);

        // receive of 18 without hold and no pops: overflow bytes dropped
        do_size(18);
        rx_log.delete();
        do_start(10'h044, 0);
        wait_free();
        check("R7", rx_log.size(), 18);
        for (int n = 0; n < 16; n++) begin
            exp_b = (n < rx_log.size()) ? rx_log[n] : 8'h00;
            check("R7", pop_data, exp_b);
            do_pop();
        end
        check("R7", rx_valid, 0);

        // zero-length receive
        got_addr = data_cnt;
        do_size(0);
        do_start(10'h012, 0);
        wait_comp();
        check("R9", data_cnt, got_addr);
        wait_free();

        // flush
        wr_ctl(0, 0, 0);
        for (int i = 0; i < 4; i++) do_push(8'h55);
        check("R11", size_q, 4);
        wr_ctl(0, 0, 1);
        check("R11", size_q, 4);
        @(negedge clk);
        check("R11", size_q, 0);
        repeat (5) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule